// File: doc/BRIEF.md
# Search Window Line Aligner

This block drives the read side of a binary search-window tile and lines up the fetched pixels for four macroblock matchers arranged as a 2x2 square. The tile is 64x64 one-bit pixels. It is held in two 32-bit-wide dual-ported memories: the "high" memory stores the left half of every tile line and the "low" memory stores the right half, both at the line number as address. Every cycle during a sweep the block sends one address pair to both memories. Port P1 serves the upper macroblock pair and port P2 serves the lower pair, so two complete 64-bit lines arrive per cycle.

Each line is shifted right according to the candidate column being searched, and the rightmost 32 bits are kept. That aligned word is split into a 16-bit slice for the left macroblock and a 16-bit slice for the right one, so a single fetch and a single shift feed two horizontally adjacent matchers. The sweep goes column by column. Within each column it fetches 48 lines from top to bottom: 33 vertical positions plus 15 lines that fill the matchers' row pipeline.

Top module: `sw_line_aligner`

## Requirements
- R1: Line bit 63 is tile pixel 0 (leftmost). The high memory word holds line bits [63:32] and the low memory word holds bits [31:0]. Both memories are read with the same P1 address and with the same P2 address.
- R2: Whenever `rd_en` is high, `rd_addr_p2` equals `rd_addr_p1` + 16.
- R3: A sweep issues 33 columns of 48 fetches each. Within a column, `rd_addr_p1` runs 0,1,...,47 on consecutive cycles. Columns follow each other with no gap, so fetch n has `rd_addr_p1` = n mod 48.
- R4: For fetch n the column is j = n div 48. The line is shifted right by 32−j and the low 32 bits are kept, so bit 31 of the aligned word is line pixel j.
- R5: Bits [31:16] of the aligned word go out on the `*_left` port and bits [15:0] on the `*_right` port. The upper pair uses the P1 line and the lower pair uses the P2 line.
- R6: The aligned words for a fetch appear with `out_valid` exactly two cycles after that fetch's address is presented. The first address appears in the cycle after `start` is sampled.
- R7: `sweep_done` is high for exactly one cycle, together with the 1584th and last aligned word of a sweep.
- R8: `start` is ignored while `busy` is high. A pulse in the middle of a sweep neither restarts nor extends it.
- R9: After reset, `rd_en`, `out_valid`, `sweep_done` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a sweep when idle |
| rd_en | output | 1 | Read enable for both memories |
| rd_addr_p1 | output | 6 | Line address on port P1 (upper pair) |
| rd_addr_p2 | output | 6 | Line address on port P2 (lower pair) |
| p1_hi_q | input | 32 | High memory data, port P1 |
| p1_lo_q | input | 32 | Low memory data, port P1 |
| p2_hi_q | input | 32 | High memory data, port P2 |
| p2_lo_q | input | 32 | Low memory data, port P2 |
| up_left | output | 16 | Upper pair, left macroblock slice |
| up_right | output | 16 | Upper pair, right macroblock slice |
| lo_left | output | 16 | Lower pair, left macroblock slice |
| lo_right | output | 16 | Lower pair, right macroblock slice |
| out_valid | output | 1 | Aligned words valid |
| sweep_done | output | 1 | Marks the final aligned word |
| busy | output | 1 | Sweep or pipeline in progress |

## Verification
The full sweep runs over a dense pseudo-random tile. Any swap of memory halves, port roles or left/right slices shows up there as a mismatch. It then runs over a tile with one set pixel per line at a different position on each line. This separates a shift in the wrong direction, or an off-by-one shift, from a correct one. A start pulse in the middle of a sweep and an immediate second sweep after completion test the restart rules, and the cycle of the first valid word pins the pipeline depth.

// File: rtl/swla_pkg.sv
package swla_pkg;
  parameter int TILE_W    = 64;
  parameter int TILE_ROWS = 64;
  parameter int MEM_W     = TILE_W / 2;
  parameter int MB_SIDE   = 16;
  parameter int SEARCH    = 32;
  parameter int COLS      = SEARCH + 1;
  parameter int FETCH_ROWS = SEARCH + MB_SIDE;
  parameter int ADDR_W    = $clog2(TILE_ROWS);
  parameter int SH_W      = $clog2(SEARCH + 1);
endpackage

// File: rtl/swla_sweep_ctrl.sv
module swla_sweep_ctrl
  import swla_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  output logic              rd_en,
  output logic [ADDR_W-1:0] addr_p1,
  output logic [ADDR_W-1:0] addr_p2,
  output logic [SH_W-1:0]   shift,
  output logic              last
);
  localparam logic [ADDR_W-1:0] ROW_END = ADDR_W'(FETCH_ROWS - 1);
  localparam logic [SH_W-1:0]   COL_END = SH_W'(COLS - 1);

  logic [SH_W-1:0]   col;
  logic [ADDR_W-1:0] row;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_en   <= 1'b0;
      col     <= '0;
      row     <= '0;
      addr_p1 <= '0;
      addr_p2 <= '0;
      shift   <= '0;
      last    <= 1'b0;
    end else if (!rd_en) begin
      if (go) begin
        rd_en   <= 1'b1;
        col     <= '0;
        row     <= '0;
        addr_p1 <= '0;
        addr_p2 <= ADDR_W'(MB_SIDE);
        shift   <= SH_W'(SEARCH);
        last    <= 1'b0;
      end
    end else if (last) begin
      rd_en <= 1'b0;
      last  <= 1'b0;
    end else begin
      if (row == ROW_END) begin
        row     <= '0;
        col     <= col + 1'b1;
        addr_p1 <= '0;
        addr_p2 <= ADDR_W'(MB_SIDE);
        shift   <= SH_W'(SEARCH) - (col + 1'b1);
      end else begin
        row     <= row + 1'b1;
        addr_p1 <= row + 1'b1;
        addr_p2 <= ADDR_W'(row + 1'b1 + ADDR_W'(MB_SIDE));
      end
      last <= (row == ROW_END - 1'b1) && (col == COL_END);
    end
  end

  assert_pair_gap_R2: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (addr_p2 == ADDR_W'(addr_p1 + ADDR_W'(MB_SIDE))));

  assert_row_step_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr_p1 != '0) |-> ($past(rd_en) && addr_p1 == $past(addr_p1) + 1'b1));

  assert_shift_range_R4: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (shift <= SH_W'(SEARCH)));

  assert_shift_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr_p1 != '0) |-> $stable(shift));
endmodule

// File: rtl/swla_line_shift.sv
module swla_line_shift
  import swla_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [MEM_W-1:0] hi_word,
  input  logic [MEM_W-1:0] lo_word,
  input  logic [SH_W-1:0]  shift,
  output logic [MEM_W-1:0] aligned
);
  logic [TILE_W-1:0] line;
  logic [TILE_W-1:0] moved;

  always_comb begin
    line  = {hi_word, lo_word};
    moved = line >> shift;
  end

  always_ff @(posedge clk) begin
    if (rst)     aligned <= '0;
    else if (en) aligned <= moved[MEM_W-1:0];
  end
endmodule

// File: rtl/sw_line_aligner.sv
module sw_line_aligner
  import swla_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  output logic               rd_en,
  output logic [ADDR_W-1:0]  rd_addr_p1,
  output logic [ADDR_W-1:0]  rd_addr_p2,
  input  logic [MEM_W-1:0]   p1_hi_q,
  input  logic [MEM_W-1:0]   p1_lo_q,
  input  logic [MEM_W-1:0]   p2_hi_q,
  input  logic [MEM_W-1:0]   p2_lo_q,
  output logic [MB_SIDE-1:0] up_left,
  output logic [MB_SIDE-1:0] up_right,
  output logic [MB_SIDE-1:0] lo_left,
  output logic [MB_SIDE-1:0] lo_right,
  output logic               out_valid,
  output logic               sweep_done,
  output logic               busy
);
  localparam int LANES = 2;

  logic [SH_W-1:0] shift_a, shift_d;
  logic            last_a, last_d, val_d;
  logic            go;

  logic [MEM_W-1:0] hi_q  [LANES];
  logic [MEM_W-1:0] lo_q  [LANES];
  logic [MEM_W-1:0] algn  [LANES];

  assign busy = rd_en | val_d | out_valid;
  assign go   = start & ~busy;

  swla_sweep_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .go      (go),
    .rd_en   (rd_en),
    .addr_p1 (rd_addr_p1),
    .addr_p2 (rd_addr_p2),
    .shift   (shift_a),
    .last    (last_a)
  );

  // Track the fetch through the memory read cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      val_d   <= 1'b0;
      shift_d <= '0;
      last_d  <= 1'b0;
    end else begin
      val_d   <= rd_en;
      shift_d <= shift_a;
      last_d  <= rd_en & last_a;
    end
  end

  assign hi_q[0] = p1_hi_q;
  assign lo_q[0] = p1_lo_q;
  assign hi_q[1] = p2_hi_q;
  assign lo_q[1] = p2_lo_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    swla_line_shift u_shift (
      .clk     (clk),
      .rst     (rst),
      .en      (val_d),
      .hi_word (hi_q[g]),
      .lo_word (lo_q[g]),
      .shift   (shift_d),
      .aligned (algn[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      sweep_done <= 1'b0;
    end else begin
      out_valid  <= val_d;
      sweep_done <= last_d;
    end
  end

  assign up_left  = algn[0][MEM_W-1:MEM_W-MB_SIDE];
  assign up_right = algn[0][MB_SIDE-1:0];
  assign lo_left  = algn[1][MEM_W-1:MEM_W-MB_SIDE];
  assign lo_right = algn[1][MB_SIDE-1:0];

  assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(rd_en, 2));

  assert_done_last_R7: assert property (@(posedge clk) disable iff (rst)
    sweep_done |-> (out_valid && !val_d));

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !$past(rd_en)) |-> ($past(start) && !$past(busy)));
endmodule

// File: tb/sw_line_aligner_tb_top.sv
`timescale 1ns/1ps
module sw_line_aligner_tb_top;
  localparam int NFETCH = 33 * 48;

  logic clk = 1'b0;
  logic rst, start;
  logic rd_en, out_valid, sweep_done, busy;
  logic [5:0] rd_addr_p1, rd_addr_p2;
  logic [31:0] p1_hi_q, p1_lo_q, p2_hi_q, p2_lo_q;
  logic [15:0] up_left, up_right, lo_left, lo_right;

  logic [31:0] mem_hi [64];
  logic [31:0] mem_lo [64];
  logic [63:0] tile   [64];

  int test_cnt = 0;
  int fail_cnt = 0;

  always #10 clk = ~clk;

  sw_line_aligner dut_i (
    .clk(clk), .rst(rst), .start(start), .rd_en(rd_en),
    .rd_addr_p1(rd_addr_p1), .rd_addr_p2(rd_addr_p2),
    .p1_hi_q(p1_hi_q), .p1_lo_q(p1_lo_q), .p2_hi_q(p2_hi_q), .p2_lo_q(p2_lo_q),
    .up_left(up_left), .up_right(up_right), .lo_left(lo_left), .lo_right(lo_right),
    .out_valid(out_valid), .sweep_done(sweep_done), .busy(busy)
  );

  // Two synchronous memories, two read ports each (R1 layout).
  always_ff @(posedge clk) begin
    if (rd_en) begin
      p1_hi_q <= mem_hi[rd_addr_p1];
      p1_lo_q <= mem_lo[rd_addr_p1];
      p2_hi_q <= mem_hi[rd_addr_p2];
      p2_lo_q <= mem_lo[rd_addr_p2];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    test_cnt++;
    if (!ok) begin
      fail_cnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_tile(input int kind);
    for (int r = 0; r < 64; r++) begin
      if (kind == 0)
        tile[r] = {32'(r * 32'h9E3779B1) ^ 32'h5A5AC3C3, 32'(r * 32'h85EBCA6B + 7)};
      else
        tile[r] = 64'h1 << ((r * 7 + 3) % 64);
      mem_hi[r] = tile[r][63:32];
      mem_lo[r] = tile[r][31:0];
    end
  endtask

  function automatic logic [31:0] expect_word(input int line, input int col);
    logic [63:0] m;
    m = tile[line] >> (32 - col);
    return m[31:0];
  endfunction

  // Runs one sweep and checks every fetch and every aligned word.
  task automatic run_sweep(input int poke_at);
    int f = 0, n = 0, cyc = 0, first_v = -1, first_rd = -1, dones = 0;
    logic [31:0] eu, el;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (dones == 0 && cyc < 3000) begin
      if (cyc == poke_at) start = 1'b1;
      else start = 1'b0;
      if (rd_en) begin
        if (first_rd < 0) first_rd = cyc;
        chk(rd_addr_p1 == 6'(f % 48), "R3 p1 address", 64'(rd_addr_p1), 64'(f % 48));
        chk(rd_addr_p2 == 6'(f % 48 + 16), "R2 p2 address", 64'(rd_addr_p2), 64'(f % 48 + 16));
        f++;
      end
      if (out_valid) begin
        if (first_v < 0) first_v = cyc;
        eu = expect_word(n % 48, n / 48);
        el = expect_word(n % 48 + 16, n / 48);
        chk({up_left, up_right, lo_left, lo_right} == {eu, el}, "R4/R5 aligned slices",
            {up_left, up_right, lo_left, lo_right}, {eu, el});
        n++;
        if (sweep_done) begin
          dones++;
          chk(n == NFETCH, "R7 done on final word", 64'(n), 64'(NFETCH));
        end
      end else begin
        chk(!sweep_done, "R7 done without word", 64'(sweep_done), 64'(0));
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(dones == 1, "R7 done seen", 64'(dones), 64'(1));
    chk(first_rd == 0, "R6 first address cycle", 64'(first_rd), 64'(0));
    chk(first_v == 2, "R6 first word cycle", 64'(first_v), 64'(2));
    chk(f == NFETCH, "R3 fetch count", 64'(f), 64'(NFETCH));
    // pipeline drained, no restart from any pulse during the sweep (R8)
    repeat (4) begin
      chk(!out_valid && !rd_en && !busy, "R8 idle after sweep",
          {61'b0, out_valid, rd_en, busy}, 64'(0));
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk(!rd_en && !out_valid && !sweep_done && !busy, "R9 reset state",
        {60'b0, rd_en, out_valid, sweep_done, busy}, 64'(0));
  endtask

  task automatic t_dense;
    load_tile(0);
    run_sweep(-1);
  endtask

  task automatic t_onehot;
    load_tile(1);
    run_sweep(-1);
  endtask

  task automatic t_start_mid;
    load_tile(0);
    run_sweep(700);
  endtask

  task automatic t_idle_no_start;
    repeat (10) begin
      chk(!rd_en && !out_valid, "R8 no sweep without start",
          {62'b0, rd_en, out_valid}, 64'(0));
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fail_cnt++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", test_cnt, fail_cnt);
    $finish;
  end

  initial begin
    rst = 1'b1;
    start = 1'b0;
    load_tile(0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_idle_no_start();
    t_dense();
    t_onehot();
    t_start_mid();
    t_dense();
    $display("  [TB] %0d tests run, %0d failed", test_cnt, fail_cnt);
    $finish;
  end
endmodule